// File: doc/BRIEF.md
# Flash Byte Program Sequencer

This block writes a run of bytes into one 64 KiB block of a byte-wide flash device. A job is accepted with a start pulse that carries a byte address and a byte count. The count is clipped so that the job never crosses the end of the block that holds the start address. For each byte, the block fetches the source byte over a request/response data port. It then issues a dummy status read, a program command and the data to the word-aligned address, and loads a 2-bit lane register that steers the byte within the word. After that it writes a read-status command and polls the status byte until the ready bit appears.

Retries happen at two levels. If the ready bit does not arrive within a per-byte window, the block clears the status and restarts the same byte from the dummy read. If the device reports a program error, the block clears the status and waits a short pause before it retries. This path is bounded by a per-job deadline that starts when the job is accepted; once the deadline has passed, a further program error ends the job with an error. After every byte is written, the block waits a settle time. It then reads the whole range back byte by byte and compares it with the source. It reports the full count when every byte matches, and zero on the first mismatch.

A one-cycle write-gate pulse, followed by a settle delay, comes before each group of command writes. All timing windows are parameters counted in clock cycles.

Top module: `flash_byte_prog`

## Requirements
- R1: The job length is the requested count, limited to 65536 minus the low 16 bits of the start address. A count of zero ends the job at once with result count 0 and no bus or source traffic. The reported count never exceeds the clipped length.
- R2: For each byte the sequence is as follows. A read at address 0x8000 comes first. Then 0x40 is written, then the data byte, both to the target address with bits 1:0 cleared. While the data byte is written, `lane_sel` holds target bits 1:0. Every flash write uses an address with bits 1:0 equal to zero.
- R3: After the data byte, 0x70 is written to address 0x10000. Reads at 0x8000 repeat until one returns bit 7 set.
- R4: If bit 7 is not seen once BYTE_TMO_CYC cycles have passed after the 0x70 write, 0x50 is written to 0x8000 and the same byte restarts from the dummy read, without fetching the source byte again.
- R5: Once ready is seen, 0xFF is written to 0x8000, so the device is in read mode at the end of each byte.
- R6: If the ready status has bit 4 set, 0x50 is written to 0x8000. Before the deadline, the block waits RETRY_WAIT_CYC cycles and retries the byte. After the deadline, the job ends with `res_err`=1 and `res_cnt`=0.
- R7: The deadline counts BLOCK_TMO_CYC cycles from the accepting clock edge, and no retry restarts it.
- R8: Each 0x40, 0x50 and 0xFF write request rises exactly SETTLE_CYC+1 cycles after a one-cycle `wgate` pulse. `wgate` never overlaps a bus or source request.
- R9: After the last byte, the block waits VERIFY_WAIT_CYC cycles, then fetches each source byte again and reads the flash at the exact byte address. On the first mismatch it stops with `res_cnt`=0 and `res_err`=0. If all bytes match, `res_cnt` is the clipped length.
- R10: `fl_req` stays high with stable address, direction and data until `fl_ack`, and `src_req` stays high with a stable index until `src_vld`.
- R11: `done` is a one-cycle pulse, followed by idle. A start pulse while `busy` is high is ignored.
- R12: During reset, `busy`, `done`, `fl_req`, `src_req` and `wgate` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job start pulse, taken only when idle |
| start_addr | input | FA_W (22) | Byte address of the first target byte |
| byte_cnt | input | BLK_LOG2+1 (17) | Requested byte count |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| res_cnt | output | BLK_LOG2+1 (17) | Bytes confirmed by readback, 0 on mismatch or error |
| res_err | output | 1 | Deadline expired on a program error |
| src_req | output | 1 | Source byte request |
| src_idx | output | BLK_LOG2 (16) | Index of the requested source byte |
| src_vld | input | 1 | Source byte valid, completes the request |
| src_data | input | 8 | Source byte |
| fl_req | output | 1 | Flash bus request |
| fl_we | output | 1 | 1 = write, 0 = read |
| fl_addr | output | FA_W (22) | Flash byte address |
| fl_wdata | output | 8 | Write data or command |
| fl_ack | input | 1 | Flash transfer complete |
| fl_rdata | input | 8 | Read data, valid with fl_ack |
| lane_sel | output | 2 | Byte-lane select register |
| wgate | output | 1 | Write-gate enable pulse |

## Verification
A wrong lane register or a wrong byte index shows up at the ports in two ways. The bytes land at the wrong address, and the readback fails within the same job, so the job reports zero. A retry path that restarts from the wrong point changes the number of source fetches and dummy reads that a job needs. A deadline that is restarted, or never checked, keeps a failing job alive past its bound, which shows within one deadline window. A gate or settle counter that is off by one cycle moves the next command write, and the bench measures that spacing on the first such write.

// File: rtl/flash_byte_prog.sv
module flash_byte_prog #(
  parameter int FA_W = 22,
  parameter int BLK_LOG2 = 16,
  parameter int unsigned SETTLE_CYC = 3125,
  parameter int unsigned BYTE_TMO_CYC = 125_000_000,
  parameter int unsigned BLOCK_TMO_CYC = 32'd3_750_000_000,
  parameter int unsigned RETRY_WAIT_CYC = 1_250_000,
  parameter int unsigned VERIFY_WAIT_CYC = 1_250_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [FA_W-1:0]     start_addr,
  input  logic [BLK_LOG2:0]   byte_cnt,
  output logic                busy,
  output logic                done,
  output logic [BLK_LOG2:0]   res_cnt,
  output logic                res_err,
  output logic                src_req,
  output logic [BLK_LOG2-1:0] src_idx,
  input  logic                src_vld,
  input  logic [7:0]          src_data,
  output logic                fl_req,
  output logic                fl_we,
  output logic [FA_W-1:0]     fl_addr,
  output logic [7:0]          fl_wdata,
  input  logic                fl_ack,
  input  logic [7:0]          fl_rdata,
  output logic [1:0]          lane_sel,
  output logic                wgate
);

  localparam int CNT_W = BLK_LOG2 + 1;
  localparam int unsigned M1 = (SETTLE_CYC > BYTE_TMO_CYC) ? SETTLE_CYC : BYTE_TMO_CYC;
  localparam int unsigned M2 = (RETRY_WAIT_CYC > VERIFY_WAIT_CYC) ? RETRY_WAIT_CYC : VERIFY_WAIT_CYC;
  localparam int unsigned MW = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(MW + 2);
  localparam int DW = $clog2(BLOCK_TMO_CYC + 2);
  localparam logic [CNT_W-1:0] BLK_BYTES = {1'b1, {BLK_LOG2{1'b0}}};
  localparam logic [FA_W-1:0] STAT_ADDR = FA_W'(32'h8000);
  localparam logic [FA_W-1:0] SCMD_ADDR = FA_W'(32'h10000);

  typedef enum logic [4:0] {
    S_IDLE, S_FETCH, S_DUMMY, S_GATE, S_SETTLE, S_CMD, S_DATA, S_STATCMD,
    S_POLL, S_CLRTO, S_RDMODE, S_CLRER, S_RWAIT, S_VWAIT, S_VFETCH, S_VREAD, S_DONE
  } st_t;

  st_t state, ret;
  logic [FA_W-1:0]     a0;
  logic [CNT_W-1:0]    n;
  logic [BLK_LOG2-1:0] idx;
  logic [7:0]          dbyte;
  logic                perr;
  logic [CW-1:0]       wcnt;
  logic [DW-1:0]       dl;
  logic [CNT_W-1:0]    res_cnt_q;
  logic                res_err_q;

  wire [CNT_W-1:0] room   = BLK_BYTES - {1'b0, start_addr[BLK_LOG2-1:0]};
  wire [CNT_W-1:0] clip   = (byte_cnt > room) ? room : byte_cnt;
  wire [FA_W-1:0]  tgt    = a0 + FA_W'(idx);
  wire [FA_W-1:0]  tgt_al = {tgt[FA_W-1:2], 2'b00};
  wire             last   = ({1'b0, idx} + 1'b1) == n;
  wire             dl_out = dl == DW'(BLOCK_TMO_CYC);

  assign busy     = state != S_IDLE;
  assign done     = state == S_DONE;
  assign res_cnt  = res_cnt_q;
  assign res_err  = res_err_q;
  assign wgate    = state == S_GATE;
  assign src_req  = (state == S_FETCH) || (state == S_VFETCH);
  assign src_idx  = idx;
  assign fl_req   = state inside {S_DUMMY, S_CMD, S_DATA, S_STATCMD, S_POLL,
                                  S_CLRTO, S_RDMODE, S_CLRER, S_VREAD};
  assign fl_we    = state inside {S_CMD, S_DATA, S_STATCMD, S_CLRTO, S_RDMODE, S_CLRER};

  always_comb begin
    fl_addr  = STAT_ADDR;
    fl_wdata = 8'h00;
    case (state)
      S_CMD:     begin fl_addr = tgt_al;    fl_wdata = 8'h40; end
      S_DATA:    begin fl_addr = tgt_al;    fl_wdata = dbyte; end
      S_STATCMD: begin fl_addr = SCMD_ADDR; fl_wdata = 8'h70; end
      S_CLRTO,
      S_CLRER:   fl_wdata = 8'h50;
      S_RDMODE:  fl_wdata = 8'hFF;
      S_VREAD:   fl_addr = tgt;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; ret <= S_IDLE; a0 <= '0; n <= '0; idx <= '0;
      dbyte <= '0; lane_sel <= '0; perr <= 1'b0; wcnt <= '0; dl <= '0;
      res_cnt_q <= '0; res_err_q <= 1'b0;
    end else begin
      if (busy && !dl_out) dl <= dl + 1'b1;
      case (state)
        S_IDLE: if (start) begin
          a0 <= start_addr; n <= clip; idx <= '0; dl <= '0;
          res_cnt_q <= '0; res_err_q <= 1'b0;
          state <= (clip == '0) ? S_DONE : S_FETCH;
        end
        S_FETCH: if (src_vld) begin dbyte <= src_data; state <= S_DUMMY; end
        S_DUMMY: if (fl_ack) begin
          lane_sel <= tgt[1:0]; ret <= S_CMD; state <= S_GATE;
        end
        S_GATE: begin wcnt <= '0; state <= S_SETTLE; end
        S_SETTLE:
          if (wcnt == CW'(SETTLE_CYC - 1)) state <= ret;
          else wcnt <= wcnt + 1'b1;
        S_CMD:  if (fl_ack) state <= S_DATA;
        S_DATA: if (fl_ack) state <= S_STATCMD;
        S_STATCMD: if (fl_ack) begin wcnt <= '0; state <= S_POLL; end
        S_POLL: begin
          if (wcnt != '1) wcnt <= wcnt + 1'b1;
          if (fl_ack) begin
            perr <= fl_rdata[4];
            if (fl_rdata[7]) begin ret <= S_RDMODE; state <= S_GATE; end
            else if (wcnt >= CW'(BYTE_TMO_CYC)) begin ret <= S_CLRTO; state <= S_GATE; end
          end
        end
        S_CLRTO: if (fl_ack) state <= S_DUMMY;
        S_RDMODE: if (fl_ack) begin
          if (perr) begin ret <= S_CLRER; state <= S_GATE; end
          else if (last) begin idx <= '0; wcnt <= '0; state <= S_VWAIT; end
          else begin idx <= idx + 1'b1; state <= S_FETCH; end
        end
        S_CLRER: if (fl_ack) begin
          if (dl_out) begin res_err_q <= 1'b1; res_cnt_q <= '0; state <= S_DONE; end
          else begin wcnt <= '0; state <= S_RWAIT; end
        end
        S_RWAIT:
          if (wcnt == CW'(RETRY_WAIT_CYC - 1)) state <= S_DUMMY;
          else wcnt <= wcnt + 1'b1;
        S_VWAIT:
          if (wcnt == CW'(VERIFY_WAIT_CYC - 1)) state <= S_VFETCH;
          else wcnt <= wcnt + 1'b1;
        S_VFETCH: if (src_vld) begin dbyte <= src_data; state <= S_VREAD; end
        S_VREAD: if (fl_ack) begin
          if (fl_rdata != dbyte) begin res_cnt_q <= '0; state <= S_DONE; end
          else if (last) begin res_cnt_q <= n; state <= S_DONE; end
          else begin idx <= idx + 1'b1; state <= S_VFETCH; end
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req && !fl_ack |=> fl_req && $stable(fl_addr) && $stable(fl_we) && $stable(fl_wdata));

  assert_src_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    src_req && !src_vld |=> src_req && $stable(src_idx));

  assert_write_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req && fl_we |-> fl_addr[1:0] == 2'b00);

  assert_gate_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wgate |-> !fl_req && !src_req);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_err |-> res_cnt == '0);

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_cnt <= n);

endmodule

// File: tb/flash_byte_prog_tb.sv
`timescale 1ns/1ps
module flash_byte_prog_tb_top;
  localparam int SETTLE = 3;
  localparam int BLKTMO = 2500;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0;
  logic [21:0] start_addr = '0;
  logic [16:0] byte_cnt = '0;
  logic busy, done, res_err, src_req, fl_req, fl_we, wgate;
  logic [16:0] res_cnt;
  logic [15:0] src_idx;
  logic [21:0] fl_addr;
  logic [7:0] fl_wdata;
  logic [1:0] lane_sel;
  logic src_vld = 1'b0, fl_ack = 1'b0;
  logic [7:0] src_data = '0, fl_rdata = '0;

  flash_byte_prog #(.FA_W(22), .BLK_LOG2(16), .SETTLE_CYC(SETTLE), .BYTE_TMO_CYC(40),
    .BLOCK_TMO_CYC(BLKTMO), .RETRY_WAIT_CYC(20), .VERIFY_WAIT_CYC(30)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .byte_cnt(byte_cnt),
    .busy(busy), .done(done), .res_cnt(res_cnt), .res_err(res_err),
    .src_req(src_req), .src_idx(src_idx), .src_vld(src_vld), .src_data(src_data),
    .fl_req(fl_req), .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_ack(fl_ack), .fl_rdata(fl_rdata), .lane_sel(lane_sel), .wgate(wgate));

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] mem [int];
  logic [7:0] srcbuf [256];
  bit stat_mode = 0, stat_err = 0, pend = 0, in_txn = 0, prev_rd = 0;
  int poll_left = 0, err_left = 0, slow_once = 0, stuck_a = -1;
  int gap = 0, flat = 0, slat = 0, last_rd = 0;
  int n_fetch = 0, n_vrd = 0, n_clr = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rd(input int a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  function automatic int exp_len(input int a, input int c);
    int room;
    room = 65536 - (a & 32'hFFFF);
    return (c > room) ? room : c;
  endfunction

  task automatic flash_txn();
    int a;
    if (!fl_we) begin
      if (fl_addr == 22'h8000 && stat_mode) begin
        fl_rdata = (poll_left > 0) ? 8'h00 : (8'h80 | (stat_err ? 8'h10 : 8'h00));
        if (poll_left > 0) poll_left--;
      end else begin
        fl_rdata = rd(int'(fl_addr));
        if (fl_addr != 22'h8000) n_vrd++;
      end
      last_rd = int'(fl_addr); prev_rd = 1;
    end else begin
      if (pend) begin
        a = int'({fl_addr[21:2], lane_sel});
        chk(fl_addr[1:0] == 2'b00, "R2 data addr align", fl_addr[1:0], 0);
        pend = 0; stat_mode = 1;
        if (err_left > 0) begin err_left--; stat_err = 1; end
        else mem[a] = (a == stuck_a) ? (fl_wdata ^ 8'h01) : fl_wdata;
        poll_left = slow_once ? 300 : 1;
        slow_once = 0;
      end else begin
        case (fl_wdata)
          8'h40: begin
            chk(prev_rd && last_rd == 32'h8000, "R2 dummy read first", last_rd, 32'h8000);
            chk(fl_addr[1:0] == 2'b00, "R2 cmd addr align", fl_addr[1:0], 0);
            pend = 1;
          end
          8'h70: begin chk(fl_addr == 22'h10000, "R3 status cmd addr", fl_addr, 32'h10000); stat_mode = 1; end
          8'h50: begin chk(fl_addr == 22'h8000, "R4 clear addr", fl_addr, 32'h8000); stat_err = 0; n_clr++; end
          8'hFF: begin chk(fl_addr == 22'h8000, "R5 read mode addr", fl_addr, 32'h8000); stat_mode = 0; end
          default: chk(0, "R2 unknown command", fl_wdata, 0);
        endcase
      end
      prev_rd = 0;
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (gap < 1000000) gap++;
      if (wgate) gap = 0;
      if (src_vld) src_vld = 0;
      else if (src_req) begin
        if (slat > 0) slat--;
        else begin
          src_vld = 1; src_data = srcbuf[src_idx[7:0]]; n_fetch++;
          slat = $urandom_range(0, 1);
        end
      end
      if (fl_ack) begin fl_ack = 0; in_txn = 0; end
      else if (fl_req) begin
        if (!in_txn) begin
          in_txn = 1; flat = $urandom_range(0, 2);
          if (fl_we && !pend && (fl_wdata == 8'h40 || fl_wdata == 8'h50 || fl_wdata == 8'hFF))
            chk(gap == SETTLE + 1, "R8 gate to command spacing", gap, SETTLE + 1);
        end
        if (flat > 0) flat--;
        else begin flash_txn(); fl_ack = 1; end
      end
    end
  end

  task automatic run_job(input logic [21:0] a, input int c, output int rc, output bit re, output int dur);
    int t0;
    mem.delete(); n_fetch = 0; n_vrd = 0; n_clr = 0;
    for (int i = 0; i < 256; i++) srcbuf[i] = 8'($urandom);
    start_addr = a; byte_cnt = 17'(c); start = 1;
    @(negedge clk); start = 0; t0 = cyc;
    while (!done && cyc - t0 < 30000) @(negedge clk);
    rc = int'(res_cnt); re = res_err; dur = cyc - t0;
    @(negedge clk);
  endtask

  task automatic good_job(input logic [21:0] a, input int c, input string tag);
    int rc, dur, e; bit re, memok;
    e = exp_len(int'(a), c);
    run_job(a, c, rc, re, dur);
    chk(rc == e, {tag, " R1 R9 result count"}, rc, e);
    chk(re == 0, {tag, " R6 no error"}, re, 0);
    memok = 1;
    for (int k = 0; k < e; k++) if (rd(int'(a) + k) != srcbuf[k]) memok = 0;
    if (rd(int'(a) - 1) != 8'hFF || rd(int'(a) + e) != 8'hFF) memok = 0;
    chk(memok, {tag, " R2 bytes at lane-steered addresses"}, memok, 1);
    chk(n_fetch == 2 * e, {tag, " R4 R9 source fetches"}, n_fetch, 2 * e);
    chk(n_vrd == e, {tag, " R9 readback reads"}, n_vrd, e);
    chk(stat_mode == 0, {tag, " R5 device in read mode"}, stat_mode, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R11 actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int rc, dur; bit re;
    logic [21:0] ra;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !fl_req && !src_req && !wgate, "R12 outputs in reset",
        {busy, done, fl_req, src_req, wgate}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && res_cnt == 0, "R12 idle after reset", busy, 0);

    good_job(22'h05_0103, 9, "plain");
    good_job(22'h0A_FFF6, 30, "clip R1");

    // R1 zero length
    run_job(22'h03_1000, 0, rc, re, dur);
    chk(rc == 0 && re == 0, "R1 zero count result", rc, 0);
    chk(n_fetch == 0 && n_vrd == 0 && dur < 4, "R1 zero count no traffic", n_fetch + n_vrd, 0);

    // R4 status timeout then restart of the same byte
    slow_once = 1;
    good_job(22'h12_2202, 6, "timeout R4");
    chk(n_clr >= 1, "R4 status clear after timeout", n_clr, 1);

    // R6 transient program errors
    err_left = 3;
    good_job(22'h21_4441, 5, "prog err R6");
    chk(n_clr == 3, "R6 one clear per error", n_clr, 3);

    // R6 R7 permanent error ends at deadline
    err_left = 1000000;
    run_job(22'h30_0010, 4, rc, re, dur);
    err_left = 0; stat_err = 0;
    chk(re == 1 && rc == 0, "R6 deadline error result", {re, 16'(rc)}, 32'h10000);
    chk(dur >= BLKTMO && dur < BLKTMO + 300, "R7 deadline from job start", dur, BLKTMO);

    // R9 readback mismatch at the fifth byte
    stuck_a = 32'h07_3304 + 4;
    run_job(22'h07_3304, 8, rc, re, dur);
    stuck_a = -1;
    chk(rc == 0 && re == 0, "R9 mismatch gives zero", rc, 0);
    chk(n_vrd == 5, "R9 stop at first mismatch", n_vrd, 5);

    // R11 start while busy is ignored
    mem.delete(); n_fetch = 0; n_vrd = 0;
    for (int i = 0; i < 256; i++) srcbuf[i] = 8'($urandom);
    start_addr = 22'h09_1203; byte_cnt = 17'd3; start = 1;
    @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    chk(busy == 1, "R11 busy during job", busy, 1);
    start_addr = 22'h2A_5000; byte_cnt = 17'd7; start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    chk(res_cnt == 3, "R11 second start ignored", res_cnt, 3);
    @(negedge clk);
    chk(!done && !busy, "R11 done one cycle", done, 0);
    chk(rd(32'h2A_5000) == 8'hFF && rd(32'h09_1205) == srcbuf[2], "R11 only first job written", 0, 0);

    // random jobs, R2 R3 R5
    for (int j = 0; j < 10; j++) begin
      int off;
      off = $urandom_range(0, 65535);
      if (off > 32'h7F00 && off < 32'h8100) off = 32'h1000;
      ra = {6'($urandom_range(1, 63)), 16'(off)};
      good_job(ra, $urandom_range(1, 20), "random R3");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule